// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a stereo stream of two's-complement audio words arriving bit by bit on a data line. A bit clock and a channel-select (word) clock frame the stream. All three lines are sampled by a faster system clock. Edges of the bit clock are found by oversampling. Each word is aligned according to one of four framing formats, chosen by a 2-bit format input. Every captured word is presented as a 24-bit signed sample.

Two framing families are supported. In the MSB-aligned formats, the word starts at a fixed distance after a channel-clock edge. In the LSB-aligned formats, the word ends on the last bit before the next channel-clock edge, so the receiver keeps a running window of recent bits and reads it at that edge. A left and a right word together form one stereo pair. The pair is released with a single-cycle strobe once the right word of a frame is complete.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst_n` is low, `left_out` and `right_out` are zero and `pair_valid` is low.
- R2: With `fmt` = 2'b00, the MSB is the bit sampled on the second bit-clock rising edge after a channel-clock change, and channel clock low marks the left word.
- R3: With `fmt` = 2'b01, the MSB is the bit sampled on the first bit-clock rising edge after a channel-clock change, and channel clock high marks the left word.
- R4: In formats 2'b00 and 2'b01, the first 24 bits of a half-frame form the sample and later bits are ignored. A word shorter than 24 bits is placed at the top of the sample, with zeros below it.
- R5: With `fmt` = 2'b10, the sample is the last 24 bits sampled before the channel-clock change, LSB last, and earlier bits of the half-frame are ignored. Channel clock high marks the left word.
- R6: With `fmt` = 2'b11, the sample is the last 16 bits before the channel-clock change, sign-extended to 24 bits. Channel clock high marks the left word.
- R7: `pair_valid` is a one-cycle pulse raised when a right word completes after a completed left word. `left_out` and `right_out` change only in a cycle where `pair_valid` is high.
- R8: A half-frame counts as complete only if channel-clock changes bound it on both sides. After reset, the half-frame in progress and a right word without a complete left word yield no pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Framing format select |
| sck_in | input | 1 | Serial bit clock |
| ws_in | input | 1 | Channel-select clock |
| sd_in | input | 1 | Serial data line |
| left_out | output | 24 | Left sample of the last pair |
| right_out | output | 24 | Right sample of the last pair |
| pair_valid | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
Each format is tried with random words. In the MSB-aligned formats, random word lengths from 8 to 32 bits tell proper zero padding apart from truncation of over-long words. Directed words sit at the signed extremes and alternate their top bits, so a swapped channel polarity or an alignment off by one slot produces wrong values. In the LSB-aligned formats, random filler bits precede the word and must vanish from the result; 16-bit words with the top bit set expose missing sign extension. Each run opens with a partial half-frame and an unpaired right word, which must produce no strobe.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt,
  input  logic                sck_in,
  input  logic                ws_in,
  input  logic                sd_in,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                pair_valid
);
  localparam int CW = $clog2(SAMPLE_W + 1);
  localparam logic [CW-1:0] WL = CW'(SAMPLE_W);
  localparam logic [1:0] F_I2S = 2'b00;
  localparam logic [1:0] F_RJS = 2'b11;

  logic [2:0] sck_p;
  logic [1:0] ws_p, sd_p;
  logic       ws_s, sd_s, rise;
  logic       ws_last, eff_last, framed, have_left;
  logic [1:0] prime;
  logic [CW-1:0] cnt;
  logic [SAMPLE_W-1:0] acc, shreg, left_hold;
  logic       msb_fmt, eff, edge_now, ended_left;
  logic [SAMPLE_W-1:0] msb_word, lsb_word, word_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0;
      ws_p  <= '0;
      sd_p  <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sck_in};
      ws_p  <= {ws_p[0], ws_in};
      sd_p  <= {sd_p[0], sd_in};
    end

  assign rise       = sck_p[1] & ~sck_p[2];
  assign ws_s       = ws_p[1];
  assign sd_s       = sd_p[1];
  assign msb_fmt    = ~fmt[1];
  assign eff        = (fmt == F_I2S) ? ws_last : ws_s;
  assign edge_now   = (prime == 2'd2) && (eff != eff_last);
  assign ended_left = (fmt == F_I2S) ? ~eff_last : eff_last;
  assign msb_word   = acc << (WL - cnt);
  assign lsb_word   = (fmt == F_RJS) ?
                      {{(SAMPLE_W-SHORT_W){shreg[SHORT_W-1]}}, shreg[SHORT_W-1:0]} : shreg;
  assign word_done  = msb_fmt ? msb_word : lsb_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ws_last    <= 1'b0;
      eff_last   <= 1'b0;
      prime      <= '0;
      framed     <= 1'b0;
      have_left  <= 1'b0;
      cnt        <= '0;
      acc        <= '0;
      shreg      <= '0;
      left_hold  <= '0;
      left_out   <= '0;
      right_out  <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (rise) begin
        ws_last  <= ws_s;
        eff_last <= eff;
        if (prime != 2'd2) prime <= prime + 2'd1;
        shreg <= {shreg[SAMPLE_W-2:0], sd_s};
        if (edge_now) begin
          framed <= 1'b1;
          acc    <= {{(SAMPLE_W-1){1'b0}}, sd_s};
          cnt    <= CW'(1);
          if (framed) begin
            if (ended_left) begin
              left_hold <= word_done;
              have_left <= 1'b1;
            end else if (have_left) begin
              left_out   <= left_hold;
              right_out  <= word_done;
              pair_valid <= 1'b1;
              have_left  <= 1'b0;
            end
          end
        end else if (cnt != WL) begin
          acc <= {acc[SAMPLE_W-2:0], sd_s};
          cnt <= cnt + CW'(1);
        end
      end
    end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((left_out != $past(left_out)) || (right_out != $past(right_out))) |-> pair_valid);

  a_r6_sign_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && fmt == F_RJS) |->
      (right_out[SAMPLE_W-1:SHORT_W] == {(SAMPLE_W-SHORT_W){right_out[SHORT_W-1]}}));

  a_r8_no_early_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (prime != 2'd2) |-> !pair_valid);
endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] fmt = 2'b00;
  logic sck = 0, ws = 0, sd = 0;
  logic [23:0] left_out, right_out;
  logic pair_valid;
  int checks = 0, fails = 0;
  logic [23:0] exp_l[$], exp_r[$];
  string tag_q[$];
  string cur_tag;
  logic pend_bit = 0;
  logic prev_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .sck_in(sck), .ws_in(ws), .sd_in(sd),
    .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid));

  task automatic check24(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pair_valid) begin
      checks++;
      if (prev_valid) begin
        fails++;
        $display("FAIL R7 strobe width actual=2+ expected=1");
      end
      if (exp_l.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 unexpected pair actual=%h/%h expected=none", left_out, right_out);
      end else begin
        cur_tag = tag_q.pop_front();
        check24({cur_tag, " left"}, left_out, exp_l.pop_front());
        check24({cur_tag, " right"}, right_out, exp_r.pop_front());
      end
    end
    prev_valid = pair_valid;
  end

  function automatic logic [23:0] exp_msb(logic [31:0] word, int nbits);
    logic [31:0] t = word << (32 - nbits);
    return t[31:8];
  endfunction

  function automatic logic [23:0] exp_lsb(logic [23:0] word, int wbits);
    return (wbits == 16) ? {{8{word[15]}}, word[15:0]} : word;
  endfunction

  task automatic slot(logic w, logic d);
    @(negedge clk);
    sck = 0;
    if (fmt == 2'b00) begin sd = pend_bit; pend_bit = d; end
    else sd = d;
    ws = w;
    repeat (HALF_SCK) @(negedge clk);
    sck = 1;
    repeat (HALF_SCK-1) @(negedge clk);
  endtask

  function automatic logic lev_left();
    return (fmt == 2'b00) ? 1'b0 : 1'b1;
  endfunction

  task automatic half_msb(logic w, logic [31:0] word, int nbits);
    for (int i = nbits-1; i >= 0; i--) slot(w, word[i]);
    for (int i = 0; i < 2 + int'($urandom % 3); i++) slot(w, 1'b0);
  endtask

  task automatic half_lsb(logic w, logic [23:0] word, int wbits);
    for (int i = 0; i < 32 - wbits; i++) slot(w, 1'($urandom % 2));
    for (int i = wbits-1; i >= 0; i--) slot(w, word[i]);
  endtask

  task automatic frame(string tag, logic [31:0] lw, logic [31:0] rw, int nbits);
    int wb = (fmt == 2'b11) ? 16 : 24;
    tag_q.push_back(tag);
    if (!fmt[1]) begin
      exp_l.push_back(exp_msb(lw, nbits));
      exp_r.push_back(exp_msb(rw, nbits));
      half_msb(lev_left(), lw, nbits);
      half_msb(~lev_left(), rw, nbits);
    end else begin
      exp_l.push_back(exp_lsb(lw[23:0], wb));
      exp_r.push_back(exp_lsb(rw[23:0], wb));
      half_lsb(lev_left(), lw[23:0], wb);
      half_lsb(~lev_left(), rw[23:0], wb);
    end
  endtask

  task automatic start_group(logic [1:0] f);
    @(negedge clk);
    rst_n = 0; sck = 0; pend_bit = 0;
    repeat (5) @(negedge clk);
    checks++;
    if (left_out !== 24'h0 || right_out !== 24'h0 || pair_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state actual=%h/%h/%b expected=0/0/0", left_out, right_out, pair_valid);
    end
    fmt = f;
    rst_n = 1;
    for (int i = 0; i < 5; i++) slot(lev_left(), 1'($urandom % 2));
    for (int i = 0; i < 32; i++) slot(~lev_left(), 1'($urandom % 2));
  endtask

  task automatic end_group(string tag);
    for (int i = 0; i < 4; i++) slot(lev_left(), 1'b0);
    repeat (20) @(negedge clk);
    checks++;
    if (exp_l.size() != 0) begin
      fails++;
      $display("FAIL %s missing pairs actual=%0d expected=0", tag, exp_l.size());
    end
    exp_l.delete(); exp_r.delete(); tag_q.delete();
  endtask

  task automatic random_frames(string tag, int n);
    for (int k = 0; k < n; k++) begin
      int nb = 8 + int'($urandom % 25);
      logic [31:0] a = $urandom, b = $urandom;
      if (fmt[1]) nb = 24;
      else begin a = a & ((nb == 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 1));
                 b = b & ((nb == 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 1)); end
      frame(tag, a, b, nb);
    end
  endtask

  initial begin
    void'($urandom(32'd20240));
    start_group(2'b00);
    frame("R2 i2s extremes", 32'h7FFFFF, 32'h800000, 24);
    frame("R2 i2s pattern", 32'hA5C3E1, 32'h5A3C1E, 24);
    frame("R4 i2s short word", 32'h1234, 32'hFFFF, 16);
    frame("R4 i2s long word", 32'hDEADBEEF, 32'h01234567, 32);
    random_frames("R2 R4 i2s random", 8);
    end_group("R2 i2s");

    start_group(2'b01);
    frame("R3 lj extremes", 32'h800000, 32'h7FFFFF, 24);
    frame("R3 lj pattern", 32'hF0F0F0, 32'h0F0F0F, 24);
    frame("R4 lj 20-bit", 32'hABCDE, 32'h80001, 20);
    frame("R4 lj 32-bit", 32'hCAFEF00D, 32'h13579BDF, 32);
    random_frames("R3 R4 lj random", 8);
    end_group("R3 lj");

    start_group(2'b10);
    frame("R5 rj24 ends", 32'hFFFFFF, 32'h000001, 24);
    frame("R5 rj24 extremes", 32'h800000, 32'h7FFFFF, 24);
    random_frames("R5 rj24 random", 6);
    end_group("R5 rj24");

    start_group(2'b11);
    frame("R6 rj16 signs", 32'h8000, 32'h7FFF, 16);
    frame("R6 rj16 minus one", 32'hFFFF, 32'h0001, 16);
    random_frames("R6 rj16 random", 6);
    end_group("R6 rj16");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule